// File: doc/BRIEF.md
# SPI Status Frame Responder

This block is the slave end of a mode-0 SPI link that reports the health of a multi-channel igniter driver. During every frame the master sends, the block shifts an 8-bit status byte out on MISO, most significant bit first. It collects the first command byte arriving on MOSI and acts on it when chip-select rises. Longer 16-bit frames simply repeat the status byte.

The status byte holds several kinds of flag:
- sticky fault latches, fed by single-cycle pulses from detectors outside the block;
- a power-up failure latch;
- a live trim-read failure level;
- a test-mode flag and a current-mode flag, both set by commands;
- a frame-error flag for frames whose bit count is neither 8 nor 16.

The top bit is an odd-parity fill over the byte. A clear command drops every sticky bit whose cause is gone.

All SPI pins are brought into the system clock domain through a synchronizer chain, and all logic runs on the system clock. After chip-select falls, the master must wait a few system clocks before the first SCK rising edge. Each SCK half period must also last a few system clocks.

Top module: `spi_status_responder`

## Requirements
- R1: The status byte is {bit7 parity, bit6 frame error, bit5 high-side short, bit4 low-side overvoltage, bit3 trim-read failure, bit2 power-up failure, bit1 test mode, bit0 current mode}.
  - The byte is driven MSB first.
  - The first bit is valid after chip-select falls, and each later bit changes after an SCK falling edge.
  - In a 16-bit frame the same byte is sent twice.
- R2: After reset, with trim_ok low, the byte read is 0x8C.
- R3: Bit 7 makes the number of ones in the 8-bit byte odd.
- R4: A frame whose SCK rising-edge count is not 8 or 16 sets the frame-error flag, and its command is ignored. The clear command 0xC0 resets the flag.
- R5: A pulse on any channel of ov_low_evt (or sc_high_evt) sets bit 4 (or bit 5). The bit holds until a clear command 0xC0 arrives in a cycle with no new pulse.
- R6: The power-up failure bit is 1 from reset, and a pwrup_fail pulse sets it again. A clear command resets it only while pwrup_done is high.
- R7: Bit 3 is the inverse of trim_ok, sampled at the start of the frame.
- R8: Command 0xE3 or 0xEC sets the test-mode bit; command 0xE0 resets it.
- R9: Command 0xA9 selects high-current mode (bit 0 = 1); command 0xA6 selects low-current mode (bit 0 = 0).
- R10: spi_miso_oe is low while chip-select is high, and an unknown opcode changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from master (mode 0) |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial status data to master |
| spi_miso_oe | output | 1 | MISO pad enable; pad is high-impedance when low |
| ov_low_evt | input | CHANNELS | Per-channel low-side overvoltage pulses |
| sc_high_evt | input | CHANNELS | Per-channel high-side short-to-ground pulses |
| pwrup_fail | input | 1 | Power-up failure pulse |
| pwrup_done | input | 1 | Power-up finished successfully (level) |
| trim_ok | input | 1 | Trim read finished with good parity (level) |

## Verification
The bench builds the block with CHANNELS=4 and SYNC_STAGES=3. It uses SCK half periods of eight system clocks, so the deeper synchronizer is exercised with little timing margin. With four channels, fault pulses can be placed on both the lowest and a middle channel, which checks the OR across channels. Frames of 0, 7, 8, 12 and 16 bits cover both accepted lengths, lengths on either side of them, and the repeated byte in long frames.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;

  typedef struct packed {
    logic par;
    logic frame_err;
    logic hs_short;
    logic ls_overv;
    logic trim_bad;
    logic pwr_bad;
    logic test_on;
    logic cur_high;
  } status_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLEAR,
    OP_TEST_ON,
    OP_TEST_OFF,
    OP_CUR_HIGH,
    OP_CUR_LOW
  } op_e;

  // bit that completes an odd count of ones over the other seven
  function automatic logic odd_fill(input logic [6:0] bits);
    return ~(^bits);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W        = 3,
  parameter int          STAGES   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign lvl = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_lvl,
  input  logic       sck_lvl,
  input  logic       mosi_lvl,
  input  logic [7:0] status_in,
  output logic       miso,
  output logic       miso_oe,
  output logic       frame_done,
  output logic       len_ok,
  output logic [7:0] cmd
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LEN_BYTE = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_WORD = CNT_W'(16);

  logic             cs_prev_q, sck_prev_q;
  logic             cs_fall, cs_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       rx_q, snap_q;
  logic [2:0]       ptr_q;
  logic             miso_q, oe_q, done_q, len_ok_q;
  logic [7:0]       cmd_q;

  assign cs_fall  =  cs_prev_q & ~cs_lvl;
  assign cs_rise  = ~cs_prev_q &  cs_lvl;
  assign sck_rise = ~sck_prev_q &  sck_lvl;
  assign sck_fall =  sck_prev_q & ~sck_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      snap_q     <= 8'h8C;
      ptr_q      <= '0;
      miso_q     <= 1'b0;
      oe_q       <= 1'b0;
      done_q     <= 1'b0;
      len_ok_q   <= 1'b0;
      cmd_q      <= '0;
    end else begin
      cs_prev_q  <= cs_lvl;
      sck_prev_q <= sck_lvl;
      done_q     <= 1'b0;
      if (cs_fall) begin
        cnt_q  <= '0;
        rx_q   <= '0;
        snap_q <= status_in;
        ptr_q  <= '0;
        miso_q <= status_in[7];
        oe_q   <= 1'b1;
      end else if (cs_rise) begin
        oe_q     <= 1'b0;
        miso_q   <= 1'b0;
        done_q   <= 1'b1;
        len_ok_q <= (cnt_q == LEN_BYTE) || (cnt_q == LEN_WORD);
        cmd_q    <= rx_q;
      end else if (!cs_lvl) begin
        if (sck_rise) begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          if (cnt_q < LEN_BYTE) rx_q <= {rx_q[6:0], mosi_lvl};
        end
        if (sck_fall) begin
          ptr_q  <= ptr_q + 1'b1;
          miso_q <= snap_q[3'd6 - ptr_q];
        end
      end
    end
  end

  assign miso       = miso_q;
  assign miso_oe    = oe_q;
  assign frame_done = done_q;
  assign len_ok     = len_ok_q;
  assign cmd        = cmd_q;

  // R3: the byte being shifted out always carries odd parity
  assert_frame_parity_R3: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (^snap_q));

  // R10: output enable stays off once chip-select has been high for a cycle
  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cs_lvl && cs_prev_q) |-> !oe_q);

  // R4: bit counter never wraps during a long frame
  assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !cs_fall) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_status_pkg::*;
#(
  parameter logic [7:0] OPC_CLEAR    = 8'hC0,
  parameter logic [7:0] OPC_TEST_UP  = 8'hE3,
  parameter logic [7:0] OPC_TEST_LOW = 8'hEC,
  parameter logic [7:0] OPC_TEST_OFF = 8'hE0,
  parameter logic [7:0] OPC_CUR_HIGH = 8'hA9,
  parameter logic [7:0] OPC_CUR_LOW  = 8'hA6
) (
  input  logic       valid,
  input  logic [7:0] cmd,
  output op_e        op
);

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      case (cmd)
        OPC_CLEAR:    op = OP_CLEAR;
        OPC_TEST_UP:  op = OP_TEST_ON;
        OPC_TEST_LOW: op = OP_TEST_ON;
        OPC_TEST_OFF: op = OP_TEST_OFF;
        OPC_CUR_HIGH: op = OP_CUR_HIGH;
        OPC_CUR_LOW:  op = OP_CUR_LOW;
        default:      op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs
  import spi_status_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  op_e                 op,
  input  logic                frame_done,
  input  logic                len_ok,
  input  logic [CHANNELS-1:0] ov_evt,
  input  logic [CHANNELS-1:0] sc_evt,
  input  logic                pwr_fail,
  input  logic                pwr_done,
  input  logic                trim_ok,
  output logic [7:0]          status
);

  logic    fe_q, ov_q, sc_q, pwr_q, tm_q, cm_q;
  logic    clr, ov_any, sc_any;
  status_t nxt;
  logic [7:0] status_q;

  assign clr    = (op == OP_CLEAR);
  assign ov_any = |ov_evt;
  assign sc_any = |sc_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_q  <= 1'b0;
      ov_q  <= 1'b0;
      sc_q  <= 1'b0;
      pwr_q <= 1'b1;
      tm_q  <= 1'b0;
      cm_q  <= 1'b0;
    end else begin
      if (ov_any)   ov_q <= 1'b1;
      else if (clr) ov_q <= 1'b0;

      if (sc_any)   sc_q <= 1'b1;
      else if (clr) sc_q <= 1'b0;

      if (pwr_fail)             pwr_q <= 1'b1;
      else if (clr && pwr_done) pwr_q <= 1'b0;

      if (frame_done && !len_ok) fe_q <= 1'b1;
      else if (clr)              fe_q <= 1'b0;

      if (op == OP_TEST_ON)       tm_q <= 1'b1;
      else if (op == OP_TEST_OFF) tm_q <= 1'b0;

      if (op == OP_CUR_HIGH)     cm_q <= 1'b1;
      else if (op == OP_CUR_LOW) cm_q <= 1'b0;
    end
  end

  always_comb begin
    nxt.frame_err = fe_q;
    nxt.hs_short  = sc_q;
    nxt.ls_overv  = ov_q;
    nxt.trim_bad  = ~trim_ok;
    nxt.pwr_bad   = pwr_q;
    nxt.test_on   = tm_q;
    nxt.cur_high  = cm_q;
    nxt.par       = odd_fill({fe_q, sc_q, ov_q, ~trim_ok, pwr_q, tm_q, cm_q});
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= 8'h8C;
    else     status_q <= nxt;
  end

  assign status = status_q;

  // R4: a frame of illegal length leaves the error flag set
  assert_fe_set_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !len_ok) |=> fe_q);

  // R5: sticky faults survive until a clear command
  assert_ov_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ov_q && op != OP_CLEAR) |=> ov_q);
  assert_sc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sc_q && op != OP_CLEAR) |=> sc_q);

  // R6: power-up failure only drops on a clear while power-up is done
  assert_pwr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_q && !(op == OP_CLEAR && pwr_done)) |=> pwr_q);

  // R8: test command sets the test-mode flag
  assert_tm_set_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TEST_ON) |=> tm_q);

  // R9: current-mode commands take effect
  assert_cm_set_R9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CUR_HIGH) |=> cm_q);

endmodule

// File: rtl/spi_status_responder.sv
module spi_status_responder
  import spi_status_pkg::*;
#(
  parameter int         CHANNELS     = 8,
  parameter int         SYNC_STAGES  = 2,
  parameter int         CNT_W        = 5,
  parameter logic [7:0] OPC_CLEAR    = 8'hC0,
  parameter logic [7:0] OPC_TEST_UP  = 8'hE3,
  parameter logic [7:0] OPC_TEST_LOW = 8'hEC,
  parameter logic [7:0] OPC_TEST_OFF = 8'hE0,
  parameter logic [7:0] OPC_CUR_HIGH = 8'hA9,
  parameter logic [7:0] OPC_CUR_LOW  = 8'hA6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  input  logic [CHANNELS-1:0] ov_low_evt,
  input  logic [CHANNELS-1:0] sc_high_evt,
  input  logic                pwrup_fail,
  input  logic                pwrup_done,
  input  logic                trim_ok
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_lvl;
  logic [7:0]       status;
  logic             frame_done, len_ok;
  logic [7:0]       cmd;
  op_e              op;

  spi_pin_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .din({spi_mosi, spi_sclk, spi_cs_n}),
    .lvl(pins_lvl)
  );

  spi_frame_engine #(
    .CNT_W(CNT_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (pins_lvl[0]),
    .sck_lvl   (pins_lvl[1]),
    .mosi_lvl  (pins_lvl[2]),
    .status_in (status),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .frame_done(frame_done),
    .len_ok    (len_ok),
    .cmd       (cmd)
  );

  spi_cmd_decode #(
    .OPC_CLEAR   (OPC_CLEAR),
    .OPC_TEST_UP (OPC_TEST_UP),
    .OPC_TEST_LOW(OPC_TEST_LOW),
    .OPC_TEST_OFF(OPC_TEST_OFF),
    .OPC_CUR_HIGH(OPC_CUR_HIGH),
    .OPC_CUR_LOW (OPC_CUR_LOW)
  ) u_dec (
    .valid(frame_done & len_ok),
    .cmd  (cmd),
    .op   (op)
  );

  spi_status_regs #(
    .CHANNELS(CHANNELS)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .frame_done(frame_done),
    .len_ok    (len_ok),
    .ov_evt    (ov_low_evt),
    .sc_evt    (sc_high_evt),
    .pwr_fail  (pwrup_fail),
    .pwr_done  (pwrup_done),
    .trim_ok   (trim_ok),
    .status    (status)
  );

endmodule

// File: tb/test_spi_status_responder.sv
`timescale 1ns/1ps
module test_spi_status_responder;

  localparam int CH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [CH-1:0] ov_evt = '0, sc_evt = '0;
  logic pfail = 1'b0, pdone = 1'b0, tok = 1'b0;

  int checks = 0;
  int errors = 0;

  // behavioural model of the flags
  bit m_fe = 0, m_ov = 0, m_sc = 0, m_pwr = 1, m_tm = 0, m_cm = 0;
  int cs_age = 0;
  logic cs_seen = 1'b1;

  always #4 clk = ~clk;

  spi_status_responder #(.CHANNELS(CH), .SYNC_STAGES(3)) i_spi_status_responder (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .ov_low_evt(ov_evt),
    .sc_high_evt(sc_evt), .pwrup_fail(pfail), .pwrup_done(pdone), .trim_ok(tok)
  );

  function automatic logic [7:0] exp_byte();
    logic [6:0] low;
    low = {m_fe, m_sc, m_ov, ~tok, m_pwr, m_tm, m_cm};
    return {~(^low), low};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // per-clock comparison of the pad enable with a cs-age model (R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n !== cs_seen) begin cs_seen = cs_n; cs_age = 0; end
      else cs_age++;
      if (cs_age >= 7) begin
        checks++;
        if (miso_oe !== !cs_n) begin
          errors++;
          $display("FAIL R10 miso_oe got=%b exp=%b", miso_oe, !cs_n);
        end
      end
    end
  end

  task automatic frame(input string tag, input int nbits, input logic [15:0] data);
    logic [7:0] e;
    logic [15:0] got, exp;
    e = exp_byte();
    got = '0; exp = '0;
    cs_n = 1'b0;
    tick(10);
    for (int i = 0; i < nbits; i++) begin
      mosi = data[(nbits - 1 - i) % 16];
      tick(8);
      if (i < 16) begin
        got[15 - i] = miso;
        exp[15 - i] = e[7 - (i % 8)];
      end
      sclk = 1'b1;
      tick(8);
      sclk = 1'b0;
    end
    tick(8);
    cs_n = 1'b1;
    tick(14);
    check(tag, got, exp);
    if (nbits == 8 || nbits == 16) begin
      case (data[nbits-1 -: 8])
        8'hC0: begin
          m_fe = 0; m_ov = 0; m_sc = 0;
          if (pdone) m_pwr = 0;
        end
        8'hE3, 8'hEC: m_tm = 1;
        8'hE0: m_tm = 0;
        8'hA9: m_cm = 1;
        8'hA6: m_cm = 0;
        default: ;
      endcase
    end else begin
      m_fe = 1;
    end
  endtask

  task automatic pulse_ov(input int idx);
    ov_evt[idx] = 1'b1; tick(1); ov_evt[idx] = 1'b0; tick(2); m_ov = 1;
  endtask

  task automatic pulse_sc(input int idx);
    sc_evt[idx] = 1'b1; tick(1); sc_evt[idx] = 1'b0; tick(2); m_sc = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got=hang exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    check("R10 reset pad enable", {15'd0, miso_oe}, 16'd0);
    // R2 R1 R3: reset byte, 8-bit no-op
    frame("R2 reset byte 0x8C", 8, 16'h0000);
    check("R2 model reset byte", {8'd0, exp_byte()}, 16'h008C);
    // R7: trim level
    tok = 1'b1; pdone = 1'b1; tick(3);
    frame("R7 trim ok clears bit3", 8, 16'h0000);
    // R6: clear with power-up done
    frame("R6 clear cmd", 8, 16'h00C0);
    frame("R6 pwr bit cleared", 8, 16'h0000);
    // R5: sticky faults on different channels
    pulse_ov(2);
    frame("R5 overvoltage latched", 8, 16'h0000);
    pulse_sc(0);
    frame("R5 overvoltage still held", 8, 16'h0000);
    frame("R5 short latched then clear", 8, 16'h00C0);
    frame("R5 faults cleared", 8, 16'h0000);
    // R8: test mode
    frame("R8 test upper", 8, 16'h00E3);
    frame("R8 test off", 8, 16'h00E0);
    frame("R8 test lower", 8, 16'h00EC);
    frame("R8 test on seen", 8, 16'h00E0);
    // R9: current mode, 16-bit frame repeats byte (R1)
    frame("R9 high current", 8, 16'h00A9);
    frame("R1 16-bit repeat and R9 low", 16, 16'hA655);
    frame("R9 low current seen", 8, 16'h0000);
    // R4: illegal lengths
    frame("R4 12-bit frame", 12, 16'h0A90);
    frame("R4 frame error shown", 8, 16'h00C0);
    frame("R4 error cleared", 7, 16'h0029);
    frame("R4 7-bit error shown", 0, 16'h0000);
    frame("R4 zero-bit error", 8, 16'h00C0);
    // R10: unknown opcode
    frame("R10 unknown opcode", 8, 16'h0055);
    frame("R10 no flag changed", 16, 16'h0000);
    // R6: failure while power-up not done
    pdone = 1'b0;
    pfail = 1'b1; tick(1); pfail = 1'b0; tick(2); m_pwr = 1;
    frame("R6 failure latched", 8, 16'h00C0);
    frame("R6 clear without done", 8, 16'h0000);
    pdone = 1'b1; tick(2);
    frame("R6 clear with done", 8, 16'h00C0);
    tok = 1'b0; tick(3);
    frame("R7 trim bad", 8, 16'h0000);
    frame("R3 parity final", 8, 16'h0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule